// File: doc/BRIEF.md
# Page access permission checker

This block decides whether a memory access that has already been translated may proceed. It receives the kind of access (load, store or instruction fetch), the privilege state, the two segment key bits, the segment no-execute bit, the two-bit page protection code, a flag saying that no translation was found, and the effective address. It returns a grant flag with the read, write and execute rights to install. When the access is refused, it returns instead the fault kind (instruction or data), a 32-bit fault status word and, for data faults, the captured effective address.

The decision is combinational. The result is registered on a one-cycle input strobe and comes out with a one-cycle valid pulse. Between strobes the registered outputs hold their values. A granted access that is not a store always comes back without write permission. The next store to the page therefore returns to the checker, which lets the page be marked as changed.

Top module: `pgperm_chk`

## Requirements
- R1: The active key is `key_user` when `user_mode` is 1 and `key_sup` when `user_mode` is 0.
- R2: With active key 0, protection codes 0, 1 and 2 give read and write, and code 3 gives read only.
- R3: With active key 1, code 0 gives no rights, codes 1 and 3 give read only, and code 2 gives read and write.
- R4: Execute right is present only when `seg_noexec` is 0. A fetch (`acc_kind`=2) with `seg_noexec`=1 faults as an instruction fault with status 0x10000000. This takes priority over a translation miss.
- R5: A fetch with `xlat_miss`=1 and `seg_noexec`=0 faults as an instruction fault with status 0x40000000.
- R6: A data access with no miss whose required right is absent faults as a data fault. The status is 0x0A000000 for a store (`acc_kind`=1) and 0x08000000 for a load (`acc_kind`=0, or 3, which is treated as a load).
- R7: A data access with `xlat_miss`=1 faults as a data fault with status 0x42000000 for a store and 0x40000000 for a load, whatever the protection.
- R8: On every data fault, `fault_addr` takes the strobed `eff_addr`. On any other result it keeps its previous value (0 after reset).
- R9: A granted access that is not a store returns `right_w`=0. A granted store returns `right_w`=1.
- R10: The required right is read for a load, write for a store and execute for a fetch, and `grant`=1 exactly when that right is present and no fault applies. When `grant`=1, `fault_status`=0 and neither fault flag is set. When the access faults, all three rights are 0.
- R11: Results appear, with `out_valid`=1, on the clock edge after the edge that samples `in_valid`=1. `out_valid` is 0 in every other cycle, and results hold while no strobe arrives. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: inputs are valid this cycle |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| user_mode | input | 1 | 1 = user privilege state |
| key_user | input | 1 | Segment key used in user state |
| key_sup | input | 1 | Segment key used in supervisor state |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| prot_code | input | 2 | Page protection code |
| xlat_miss | input | 1 | No translation was found |
| eff_addr | input | AW | Effective address of the access |
| out_valid | output | 1 | One-cycle result pulse |
| grant | output | 1 | Access allowed |
| right_r | output | 1 | Read right granted |
| right_w | output | 1 | Write right granted |
| right_x | output | 1 | Execute right granted |
| fault_instr | output | 1 | Instruction fault |
| fault_data | output | 1 | Data fault |
| fault_status | output | 32 | Fault status word, 0 on grant |
| fault_addr | output | AW | Captured effective address of the last data fault |

## Verification
Several fault causes can apply to one access in the same cycle, and only one of them may win. A fetch from a no-execute segment that also misses must report the no-execute status. A data access that misses on a page with no rights must report the miss status and not the protection status. The bench provokes these collisions by sweeping every combination of access kind, privilege, both keys, no-execute, protection code and miss flag. It judges each result against a priority ladder computed on its own, and checks between strobes that the fault address and results do not move.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_INSTR = 2'd1,
    FK_DATA  = 2'd2
  } fault_kind_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  localparam int STW = 32;

  localparam logic [STW-1:0] ST_NONE    = 32'h0000_0000;
  localparam logic [STW-1:0] ST_NOEXEC  = 32'h1000_0000;
  localparam logic [STW-1:0] ST_PROT_LD = 32'h0800_0000;
  localparam logic [STW-1:0] ST_PROT_ST = 32'h0A00_0000;
  localparam logic [STW-1:0] ST_MISS_LD = 32'h4000_0000;
  localparam logic [STW-1:0] ST_MISS_ST = 32'h4200_0000;

  // Key choice by privilege state.
  function automatic logic pick_key(logic user, logic k_user, logic k_sup);
    return user ? k_user : k_sup;
  endfunction

  // Two-table decode of the page protection code.
  function automatic rights_t prot_decode(logic key, logic [1:0] pp, logic nx);
    rights_t rt;
    rt = '0;
    if (!key) begin
      rt.r = 1'b1;
      rt.w = (pp != 2'd3);
    end else begin
      rt.r = (pp != 2'd0);
      rt.w = (pp == 2'd2);
    end
    rt.x = ~nx;
    return rt;
  endfunction

  // Right that an access of a given kind needs.
  function automatic rights_t need_of(acc_kind_e k);
    rights_t rt;
    rt = '0;
    case (k)
      ACC_STORE: rt.w = 1'b1;
      ACC_FETCH: rt.x = 1'b1;
      default:   rt.r = 1'b1;
    endcase
    return rt;
  endfunction

endpackage

// File: rtl/pgperm_decode.sv
module pgperm_decode
  import pgperm_pkg::*;
(
  input  logic       user_mode,
  input  logic       key_user,
  input  logic       key_sup,
  input  logic       seg_noexec,
  input  logic [1:0] prot_code,
  output logic       key_sel,
  output rights_t    table_rights
);

  always_comb begin
    key_sel      = pick_key(user_mode, key_user, key_sup);
    table_rights = prot_decode(key_sel, prot_code, seg_noexec);
  end

endmodule

// File: rtl/pgperm_judge.sv
module pgperm_judge
  import pgperm_pkg::*;
(
  input  logic [1:0]     acc_kind,
  input  logic           seg_noexec,
  input  logic           xlat_miss,
  input  rights_t        table_rights,
  output logic           ev_noexec,
  output logic           ev_miss,
  output logic           ev_prot,
  output logic           grant,
  output rights_t        rights_out,
  output fault_kind_e    fkind,
  output logic [STW-1:0] status
);

  acc_kind_e kind;
  rights_t   need;
  logic      is_fetch;
  logic      is_store;

  always_comb begin
    kind     = acc_kind_e'(acc_kind);
    is_fetch = (kind == ACC_FETCH);
    is_store = (kind == ACC_STORE);
    need     = need_of(kind);

    // Fault ladder: no-execute, then miss, then protection.
    ev_noexec = is_fetch & seg_noexec;
    ev_miss   = ~ev_noexec & xlat_miss;
    ev_prot   = ~ev_noexec & ~xlat_miss & ((need & ~table_rights) != '0);
    grant     = ~(ev_noexec | ev_miss | ev_prot);

    rights_out = '0;
    if (grant) begin
      rights_out.r = table_rights.r;
      rights_out.x = table_rights.x;
      rights_out.w = table_rights.w & is_store;
    end

    if (grant)         fkind = FK_NONE;
    else if (is_fetch) fkind = FK_INSTR;
    else               fkind = FK_DATA;

    if (ev_noexec)    status = ST_NOEXEC;
    else if (ev_miss) status = is_store ? ST_MISS_ST : ST_MISS_LD;
    else if (ev_prot) status = is_store ? ST_PROT_ST : ST_PROT_LD;
    else              status = ST_NONE;
  end

endmodule

// File: rtl/pgperm_outreg.sv
module pgperm_outreg
  import pgperm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           grant_c,
  input  rights_t        rights_c,
  input  fault_kind_e    fkind_c,
  input  logic [STW-1:0] status_c,
  input  logic [AW-1:0]  eff_addr,
  output logic           out_valid,
  output logic           grant,
  output rights_t        rights,
  output logic           fault_instr,
  output logic           fault_data,
  output logic [STW-1:0] fault_status,
  output logic [AW-1:0]  fault_addr
);

  logic cap_addr;
  assign cap_addr = in_valid & (fkind_c == FK_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      grant        <= 1'b0;
      rights       <= '0;
      fault_instr  <= 1'b0;
      fault_data   <= 1'b0;
      fault_status <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        grant        <= grant_c;
        rights       <= rights_c;
        fault_instr  <= (fkind_c == FK_INSTR);
        fault_data   <= (fkind_c == FK_DATA);
        fault_status <= status_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_addr <= '0;
    else if (cap_addr) fault_addr <= eff_addr;
  end

endmodule

// File: rtl/pgperm_chk.sv
module pgperm_chk
  import pgperm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    acc_kind,
  input  logic          user_mode,
  input  logic          key_user,
  input  logic          key_sup,
  input  logic          seg_noexec,
  input  logic [1:0]    prot_code,
  input  logic          xlat_miss,
  input  logic [AW-1:0] eff_addr,
  output logic          out_valid,
  output logic          grant,
  output logic          right_r,
  output logic          right_w,
  output logic          right_x,
  output logic          fault_instr,
  output logic          fault_data,
  output logic [31:0]   fault_status,
  output logic [AW-1:0] fault_addr
);

  logic           key_sel;
  rights_t        table_rights;
  logic           ev_noexec;
  logic           ev_miss;
  logic           ev_prot;
  logic           grant_c;
  rights_t        rights_c;
  fault_kind_e    fkind_c;
  logic [STW-1:0] status_c;
  rights_t        rights_q;

  pgperm_decode u_decode (
    .user_mode    (user_mode),
    .key_user     (key_user),
    .key_sup      (key_sup),
    .seg_noexec   (seg_noexec),
    .prot_code    (prot_code),
    .key_sel      (key_sel),
    .table_rights (table_rights)
  );

  pgperm_judge u_judge (
    .acc_kind     (acc_kind),
    .seg_noexec   (seg_noexec),
    .xlat_miss    (xlat_miss),
    .table_rights (table_rights),
    .ev_noexec    (ev_noexec),
    .ev_miss      (ev_miss),
    .ev_prot      (ev_prot),
    .grant        (grant_c),
    .rights_out   (rights_c),
    .fkind        (fkind_c),
    .status       (status_c)
  );

  pgperm_outreg #(.AW(AW)) u_outreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .grant_c      (grant_c),
    .rights_c     (rights_c),
    .fkind_c      (fkind_c),
    .status_c     (status_c),
    .eff_addr     (eff_addr),
    .out_valid    (out_valid),
    .grant        (grant),
    .rights       (rights_q),
    .fault_instr  (fault_instr),
    .fault_data   (fault_data),
    .fault_status (fault_status),
    .fault_addr   (fault_addr)
  );

  assign right_r = rights_q.r;
  assign right_w = rights_q.w;
  assign right_x = rights_q.x;

endmodule

// File: rtl/pgperm_sva.sv
module pgperm_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    acc_kind,
  input logic [AW-1:0] eff_addr,
  input logic          ev_noexec,
  input logic          ev_miss,
  input logic          ev_prot,
  input logic          out_valid,
  input logic          grant,
  input logic          right_w,
  input logic          fault_instr,
  input logic          fault_data,
  input logic [31:0]   fault_status,
  input logic [AW-1:0] fault_addr
);

  logic data_fault_in;
  assign data_fault_in = in_valid & (acc_kind != 2'd2) & (ev_miss | ev_prot);

  // R11
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({grant, fault_instr, fault_data}) == 1));

  // R10
  grant_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && grant) |-> (fault_status == 32'h0));

  // R9
  nostore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind != 2'd1) |=> !right_w);

  // R4
  noexec_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_noexec) |=> (fault_instr && fault_status == 32'h1000_0000));

  // R7
  store_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_miss && acc_kind == 2'd1) |=> (fault_data && fault_status == 32'h4200_0000));

  // R8
  addr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_fault_in |=> (fault_addr == $past(eff_addr)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_fault_in |=> $stable(fault_addr));

endmodule

bind pgperm_chk pgperm_sva #(.AW(AW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .acc_kind     (acc_kind),
  .eff_addr     (eff_addr),
  .ev_noexec    (ev_noexec),
  .ev_miss      (ev_miss),
  .ev_prot      (ev_prot),
  .out_valid    (out_valid),
  .grant        (grant),
  .right_w      (right_w),
  .fault_instr  (fault_instr),
  .fault_data   (fault_data),
  .fault_status (fault_status),
  .fault_addr   (fault_addr)
);

// File: tb/pgperm_chk_bench.sv
module pgperm_chk_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    acc_kind = '0;
  logic          user_mode = 1'b0;
  logic          key_user = 1'b0;
  logic          key_sup = 1'b0;
  logic          seg_noexec = 1'b0;
  logic [1:0]    prot_code = '0;
  logic          xlat_miss = 1'b0;
  logic [AW-1:0] eff_addr = '0;
  logic          out_valid, grant, right_r, right_w, right_x;
  logic          fault_instr, fault_data;
  logic [31:0]   fault_status;
  logic [AW-1:0] fault_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pgperm_chk #(.AW(AW)) u_pgperm_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_kind(acc_kind),
    .user_mode(user_mode), .key_user(key_user), .key_sup(key_sup),
    .seg_noexec(seg_noexec), .prot_code(prot_code), .xlat_miss(xlat_miss),
    .eff_addr(eff_addr), .out_valid(out_valid), .grant(grant),
    .right_r(right_r), .right_w(right_w), .right_x(right_x),
    .fault_instr(fault_instr), .fault_data(fault_data),
    .fault_status(fault_status), .fault_addr(fault_addr)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      summary();
    end
  end

  initial begin
    logic [AW-1:0] exp_fa;
    exp_fa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 reset", {out_valid, grant, right_r, right_w, right_x, fault_instr,
                        fault_data, fault_status, fault_addr},
          64'h0);

    for (int c = 0; c < 512; c++) begin
      logic [1:0] k, pp;
      logic u, ku, ks, nx, ms, key, er, ew, ex, ok, st, fe, eg, efi, efd;
      logic [31:0] es;
      string tg;
      k  = c[1:0];
      u  = c[2];
      ku = c[3];
      ks = c[4];
      nx = c[5];
      pp = c[7:6];
      ms = c[8];

      // Expected rights, written as explicit tables (R1, R2, R3, R4)
      key = u ? ku : ks;
      if (key == 1'b0) begin
        er = 1'b1;
        ew = (pp == 2'd3) ? 1'b0 : 1'b1;
      end else begin
        er = (pp == 2'd0) ? 1'b0 : 1'b1;
        ew = (pp == 2'd2) ? 1'b1 : 1'b0;
      end
      ex = nx ? 1'b0 : 1'b1;
      st = (k == 2'd1);
      fe = (k == 2'd2);
      ok = fe ? ex : (st ? ew : er);

      eg = 1'b0; efi = 1'b0; efd = 1'b0; es = 32'h0;
      if (fe && nx) begin
        efi = 1'b1; es = 32'h1000_0000; tg = "R4";
      end else if (fe && ms) begin
        efi = 1'b1; es = 32'h4000_0000; tg = "R5";
      end else if (ms) begin
        efd = 1'b1; es = st ? 32'h4200_0000 : 32'h4000_0000; tg = "R7";
      end else if (!ok) begin
        if (fe) begin efi = 1'b1; es = 32'h0800_0000; end
        else begin efd = 1'b1; es = st ? 32'h0A00_0000 : 32'h0800_0000; end
        tg = "R6";
      end else begin
        eg = 1'b1; tg = (key ? "R3" : "R2");
      end

      acc_kind   = k;
      user_mode  = u;
      key_user   = ku;
      key_sup    = ks;
      seg_noexec = nx;
      prot_code  = pp;
      xlat_miss  = ms;
      eff_addr   = 32'h1357_0000 ^ (c * 32'h0101_0103);
      in_valid   = 1'b1;
      if (efd) exp_fa = eff_addr;
      @(negedge clk);
      in_valid = 1'b0;

      check("R11 valid pulse", out_valid, 1);
      check({tg, " R10 grant"}, grant, eg);
      check({tg, " status"}, fault_status, es);
      check({tg, " fault kind"}, {fault_instr, fault_data}, {efi, efd});
      if (eg)
        check({tg, " R1 R9 rights"}, {right_x, right_w, right_r}, {ex, ew & st, er});
      else
        check("R10 rights cleared on fault", {right_x, right_w, right_r}, 3'b000);
      check("R8 fault addr", fault_addr, exp_fa);

      // Scramble inputs without a strobe; results must hold (R11, R8).
      xlat_miss = ~ms;
      acc_kind  = 2'd1;
      eff_addr  = ~eff_addr;
      @(negedge clk);
      check("R11 idle", out_valid, 0);
      check("R11 hold", {grant, fault_status, fault_instr, fault_data}, {eg, es, efi, efd});
      check("R8 addr hold", fault_addr, exp_fa);
    end

    done = 1'b1;
    summary();
  end

endmodule